// File: doc/BRIEF.md
# Event-Triggered Burst DMA Channel

This block is one DMA channel that copies words from a source memory into a destination register. The work is organised in two nested levels. A transfer is a run of bursts, and a burst is a run of words. A peripheral event request starts each burst. Software can also start a burst directly through a force bit, which is how the first burst of a transfer is usually started.

The channel keeps a current source address and a current destination address. Inside a burst, each address moves by its own per-word step. After the last word of a burst, each address moves by its own per-burst step instead. Both steps are signed, so an address can walk backwards. A destination per-burst step of zero keeps every write on the same peripheral register.

Software sets the channel up through a small word-addressed register port. Both size fields hold the count minus one. Writing the run bit reloads the counters and addresses and enables the channel. After the final burst the channel drops its running status, pulses its interrupt, and stays idle until run is written again.

Top module: `evdma_channel`

## Requirements
- R1: After reset, the control/status register (offset 0) reads 0, and `mem_rd_en`, `dst_wr_en` and `irq` are low.
- R2: The word-size register (offset 1) holds words per burst minus one, and the burst-size register (offset 2) holds bursts per transfer minus one. A transfer therefore writes exactly (W+1)·(B+1) words.
- R3: Between two words of the same burst, the source address adds the source word step (offset 3) and the destination address adds the destination word step (offset 4).
- R4: After the last word of a burst, the source burst step (offset 5) is added to the last source address used, and the destination burst step (offset 6) is added to the last destination address used. The addresses reload from offsets 7 and 8 when run is written.
- R5: A one-cycle pulse on `periph_evt` sets the event flag (status bit 2). While running and not halted, the flag lets exactly one burst start, and starting the burst clears the flag. The first read of that burst is issued two cycles after the pulse.
- R6: An event that arrives while a burst is in flight is held, and it starts the next burst as soon as the current one ends.
- R7: Writing control bit 2 (force) sets the event flag with no peripheral event, and a burst follows.
- R8: Writing control bit 1 (halt) sets status bit 1. While halted, no new burst starts and the event flag is kept. Writing control bit 3 (resume) clears halt, and the pending burst then runs.
- R9: When the last burst ends, status bit 0 (running) clears. `irq` is high for exactly one cycle, in the same cycle as the last destination write. No further bursts start until control bit 0 (run) is written again. Writing run reloads the counters and addresses.
- R10: Offset 11 reads the burst counter, which loads B at run and decreases by one after each non-final burst. Offset 9 sets the wrap size, which is all ones after reset and disables wrapping. Offset 12 reads the wrap counter, which loads the wrap size at run and decreases by one per completed burst. Offsets 13 and 14 read the current source and destination addresses.
- R11: Step values are 16-bit two's complement. Address arithmetic wraps modulo 2^AW, so stepping −1 from address 0 gives the all-ones address.
- R12: Each word takes two cycles. `mem_rd_en` is high for one cycle with the source address. Read data is expected one cycle later. `dst_wr_en` rises two cycles after the matching read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word offset (write and read) |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Registered read data for `cfg_addr` of the previous cycle |
| periph_evt | input | 1 | Peripheral event request pulse |
| mem_rd_en | output | 1 | Source memory read strobe |
| mem_rd_addr | output | AW | Source memory read address |
| mem_rd_data | input | DW | Source read data, valid one cycle after the strobe |
| dst_wr_en | output | 1 | Destination write strobe |
| dst_wr_addr | output | AW | Destination write address |
| dst_wr_data | output | DW | Destination write data |
| irq | output | 1 | One-cycle end-of-transfer interrupt |

## Verification
The bench builds the channel with its default AW = 16 and DW = 16, so the register width equals the address width. With this setting, negative steps can carry an address below zero to 0xFFFF, and that result is read back in full through the address registers. The memory model decodes the low eight address bits. This lets scattered and wrapped addresses reach distinct, known data words, and every write is compared against an address walk computed separately in the bench.

// File: rtl/evdma_pkg.sv
package evdma_pkg;
  localparam int RW     = 16;
  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] OFS_CTRL      = 4'd0;
  localparam logic [REG_AW-1:0] OFS_WORDS     = 4'd1;
  localparam logic [REG_AW-1:0] OFS_BURSTS    = 4'd2;
  localparam logic [REG_AW-1:0] OFS_SRC_WSTEP = 4'd3;
  localparam logic [REG_AW-1:0] OFS_DST_WSTEP = 4'd4;
  localparam logic [REG_AW-1:0] OFS_SRC_BSTEP = 4'd5;
  localparam logic [REG_AW-1:0] OFS_DST_BSTEP = 4'd6;
  localparam logic [REG_AW-1:0] OFS_SRC_BASE  = 4'd7;
  localparam logic [REG_AW-1:0] OFS_DST_BASE  = 4'd8;
  localparam logic [REG_AW-1:0] OFS_WRAP      = 4'd9;
  localparam logic [REG_AW-1:0] OFS_WORD_CNT  = 4'd10;
  localparam logic [REG_AW-1:0] OFS_BURST_CNT = 4'd11;
  localparam logic [REG_AW-1:0] OFS_WRAP_CNT  = 4'd12;
  localparam logic [REG_AW-1:0] OFS_SRC_CUR   = 4'd13;
  localparam logic [REG_AW-1:0] OFS_DST_CUR   = 4'd14;

  // control write bits
  localparam int CB_RUN    = 0;
  localparam int CB_HALT   = 1;
  localparam int CB_FORCE  = 2;
  localparam int CB_RESUME = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RD, ST_WR} eng_state_t;

  typedef struct packed {
    logic [RW-1:0] words_m1;
    logic [RW-1:0] bursts_m1;
    logic [RW-1:0] src_wstep;
    logic [RW-1:0] dst_wstep;
    logic [RW-1:0] src_bstep;
    logic [RW-1:0] dst_bstep;
    logic [RW-1:0] src_base;
    logic [RW-1:0] dst_base;
    logic [RW-1:0] wrap_size;
  } dma_cfg_t;
endpackage

// File: rtl/evdma_regs.sv
module evdma_regs
  import evdma_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [RW-1:0]     cfg_wdata,
  output logic [RW-1:0]     cfg_rdata,
  output dma_cfg_t          cfg,
  output logic              run_req,
  output logic              halt_req,
  output logic              force_req,
  output logic              resume_req,
  input  logic [3:0]        status,
  input  logic [RW-1:0]     word_cnt,
  input  logic [RW-1:0]     burst_cnt,
  input  logic [RW-1:0]     wrap_cnt,
  input  logic [AW-1:0]     src_cur,
  input  logic [AW-1:0]     dst_cur
);
  logic ctrl_wr;
  assign ctrl_wr    = cfg_we && (cfg_addr == OFS_CTRL);
  assign run_req    = ctrl_wr && cfg_wdata[CB_RUN];
  assign halt_req   = ctrl_wr && cfg_wdata[CB_HALT];
  assign force_req  = ctrl_wr && cfg_wdata[CB_FORCE];
  assign resume_req = ctrl_wr && cfg_wdata[CB_RESUME];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg           <= '0;
      cfg.wrap_size <= '1;
    end else if (cfg_we) begin
      case (cfg_addr)
        OFS_WORDS:     cfg.words_m1  <= cfg_wdata;
        OFS_BURSTS:    cfg.bursts_m1 <= cfg_wdata;
        OFS_SRC_WSTEP: cfg.src_wstep <= cfg_wdata;
        OFS_DST_WSTEP: cfg.dst_wstep <= cfg_wdata;
        OFS_SRC_BSTEP: cfg.src_bstep <= cfg_wdata;
        OFS_DST_BSTEP: cfg.dst_bstep <= cfg_wdata;
        OFS_SRC_BASE:  cfg.src_base  <= cfg_wdata;
        OFS_DST_BASE:  cfg.dst_base  <= cfg_wdata;
        OFS_WRAP:      cfg.wrap_size <= cfg_wdata;
        default: ;
      endcase
    end
  end

  logic [RW-1:0] rd_mux;
  always_comb begin
    case (cfg_addr)
      OFS_CTRL:      rd_mux = RW'(status);
      OFS_WORDS:     rd_mux = cfg.words_m1;
      OFS_BURSTS:    rd_mux = cfg.bursts_m1;
      OFS_SRC_WSTEP: rd_mux = cfg.src_wstep;
      OFS_DST_WSTEP: rd_mux = cfg.dst_wstep;
      OFS_SRC_BSTEP: rd_mux = cfg.src_bstep;
      OFS_DST_BSTEP: rd_mux = cfg.dst_bstep;
      OFS_SRC_BASE:  rd_mux = cfg.src_base;
      OFS_DST_BASE:  rd_mux = cfg.dst_base;
      OFS_WRAP:      rd_mux = cfg.wrap_size;
      OFS_WORD_CNT:  rd_mux = word_cnt;
      OFS_BURST_CNT: rd_mux = burst_cnt;
      OFS_WRAP_CNT:  rd_mux = wrap_cnt;
      OFS_SRC_CUR:   rd_mux = RW'(src_cur);
      OFS_DST_CUR:   rd_mux = RW'(dst_cur);
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_mux;
  end
endmodule

// File: rtl/evdma_trig.sv
module evdma_trig (
  input  logic clk,
  input  logic rst,
  input  logic periph_evt,
  input  logic force_req,
  input  logic take,
  output logic evt_flag
);
  // a new request wins over the clear of the burst being launched
  always_ff @(posedge clk) begin
    if (rst) evt_flag <= 1'b0;
    else     evt_flag <= (evt_flag && !take) || periph_evt || force_req;
  end

  // R5
  evt_latch_chk: assert property (@(posedge clk) disable iff (rst)
    periph_evt |=> evt_flag);
endmodule

// File: rtl/evdma_engine.sv
module evdma_engine
  import evdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  dma_cfg_t      cfg,
  input  logic          run_req,
  input  logic          halt_req,
  input  logic          resume_req,
  input  logic          evt_flag,
  output logic          take,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic          dst_wr_en,
  output logic [AW-1:0] dst_wr_addr,
  output logic [DW-1:0] dst_wr_data,
  output logic          irq,
  output logic          running,
  output logic          halted,
  output logic          busy,
  output logic [RW-1:0] word_cnt,
  output logic [RW-1:0] burst_cnt,
  output logic [RW-1:0] wrap_cnt,
  output logic [AW-1:0] src_cur,
  output logic [AW-1:0] dst_cur
);
  localparam logic [RW-1:0] ONE = RW'(1);

  eng_state_t state;

  function automatic logic [AW-1:0] step_add(input logic [AW-1:0] a, input logic [RW-1:0] s);
    return a + AW'($signed(s));
  endfunction

  logic last_word, last_burst, run_ok;
  assign last_word  = (word_cnt == '0);
  assign last_burst = (burst_cnt == '0);
  assign run_ok     = run_req && (state == ST_IDLE || state == ST_WAIT);
  assign take       = (state == ST_WAIT) && evt_flag && !halted && !run_req;
  assign busy       = (state == ST_RD) || (state == ST_WR);
  assign mem_rd_en  = (state == ST_RD);
  assign mem_rd_addr = src_cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      running     <= 1'b0;
      halted      <= 1'b0;
      irq         <= 1'b0;
      dst_wr_en   <= 1'b0;
      dst_wr_addr <= '0;
      dst_wr_data <= '0;
      word_cnt    <= '0;
      burst_cnt   <= '0;
      wrap_cnt    <= '0;
      src_cur     <= '0;
      dst_cur     <= '0;
    end else begin
      irq       <= 1'b0;
      dst_wr_en <= 1'b0;
      if (run_ok) begin
        state     <= ST_WAIT;
        running   <= 1'b1;
        halted    <= 1'b0;
        word_cnt  <= cfg.words_m1;
        burst_cnt <= cfg.bursts_m1;
        wrap_cnt  <= cfg.wrap_size;
        src_cur   <= AW'(cfg.src_base);
        dst_cur   <= AW'(cfg.dst_base);
      end else begin
        if (halt_req)        halted <= 1'b1;
        else if (resume_req) halted <= 1'b0;
        case (state)
          ST_WAIT: if (take) begin
            state    <= ST_RD;
            word_cnt <= cfg.words_m1;
          end
          ST_RD: state <= ST_WR;
          ST_WR: begin
            dst_wr_en   <= 1'b1;
            dst_wr_addr <= dst_cur;
            dst_wr_data <= mem_rd_data;
            if (last_word) begin
              src_cur  <= step_add(src_cur, cfg.src_bstep);
              dst_cur  <= step_add(dst_cur, cfg.dst_bstep);
              wrap_cnt <= wrap_cnt - ONE;
              if (last_burst) begin
                state   <= ST_IDLE;
                running <= 1'b0;
                irq     <= 1'b1;
              end else begin
                burst_cnt <= burst_cnt - ONE;
                state     <= ST_WAIT;
              end
            end else begin
              word_cnt <= word_cnt - ONE;
              src_cur  <= step_add(src_cur, cfg.src_wstep);
              dst_cur  <= step_add(dst_cur, cfg.dst_wstep);
              state    <= ST_RD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R12
  rd_single_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);
  // R12
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
    dst_wr_en |-> $past(mem_rd_en, 2));
  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  // R9
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (!running && dst_wr_en));
  // R8
  halt_block_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && halted && !run_req) |=> !mem_rd_en);
endmodule

// File: rtl/evdma_channel.sv
module evdma_channel
  import evdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [RW-1:0]     cfg_wdata,
  output logic [RW-1:0]     cfg_rdata,
  input  logic              periph_evt,
  output logic              mem_rd_en,
  output logic [AW-1:0]     mem_rd_addr,
  input  logic [DW-1:0]     mem_rd_data,
  output logic              dst_wr_en,
  output logic [AW-1:0]     dst_wr_addr,
  output logic [DW-1:0]     dst_wr_data,
  output logic              irq
);
  dma_cfg_t      cfg;
  logic          run_req, halt_req, force_req, resume_req;
  logic          take, evt_flag, running, halted, busy;
  logic [RW-1:0] word_cnt, burst_cnt, wrap_cnt;
  logic [AW-1:0] src_cur, dst_cur;
  logic [3:0]    status;

  assign status = {busy, evt_flag, halted, running};

  evdma_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg(cfg),
    .run_req(run_req), .halt_req(halt_req), .force_req(force_req),
    .resume_req(resume_req), .status(status), .word_cnt(word_cnt),
    .burst_cnt(burst_cnt), .wrap_cnt(wrap_cnt), .src_cur(src_cur),
    .dst_cur(dst_cur)
  );

  evdma_trig u_trig (
    .clk(clk), .rst(rst), .periph_evt(periph_evt), .force_req(force_req),
    .take(take), .evt_flag(evt_flag)
  );

  evdma_engine #(.AW(AW), .DW(DW)) u_engine (
    .clk(clk), .rst(rst), .cfg(cfg), .run_req(run_req), .halt_req(halt_req),
    .resume_req(resume_req), .evt_flag(evt_flag), .take(take),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .dst_wr_en(dst_wr_en), .dst_wr_addr(dst_wr_addr), .dst_wr_data(dst_wr_data),
    .irq(irq), .running(running), .halted(halted), .busy(busy),
    .word_cnt(word_cnt), .burst_cnt(burst_cnt), .wrap_cnt(wrap_cnt),
    .src_cur(src_cur), .dst_cur(dst_cur)
  );
endmodule

// File: tb/evdma_channel_tb.sv
module evdma_channel_tb;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_addr = '0;
  logic [15:0]   cfg_wdata = '0;
  logic [15:0]   cfg_rdata;
  logic          periph_evt = 1'b0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [DW-1:0] mem_rd_data = '0;
  logic          dst_wr_en;
  logic [AW-1:0] dst_wr_addr;
  logic [DW-1:0] dst_wr_data;
  logic          irq;

  always #4 clk = ~clk;

  evdma_channel #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .periph_evt(periph_evt),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .dst_wr_en(dst_wr_en), .dst_wr_addr(dst_wr_addr), .dst_wr_data(dst_wr_data),
    .irq(irq)
  );

  logic [DW-1:0] mem [256];
  initial for (int i = 0; i < 256; i++) mem[i] = 16'hC300 ^ DW'(i * 37);
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[7:0]];

  logic [AW-1:0] wa [64];
  logic [DW-1:0] wd [64];
  int wn = 0;
  int irq_cnt = 0;
  logic irq_with_wr = 1'b0;
  always @(posedge clk) begin
    if (!rst && dst_wr_en && wn < 64) begin
      wa[wn] = dst_wr_addr; wd[wn] = dst_wr_data; wn = wn + 1;
    end
    if (!rst && irq) begin
      irq_cnt = irq_cnt + 1; irq_with_wr = dst_wr_en;
    end
  end

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); cfg_addr = a;
    @(negedge clk); d = cfg_rdata;
  endtask

  task automatic pulse_evt();
    @(negedge clk); periph_evt = 1'b1;
    @(negedge clk); periph_evt = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input int w_m1, input int b_m1,
                       input logic [15:0] sb, input logic [15:0] sws, input logic [15:0] sbs,
                       input logic [15:0] db, input logic [15:0] dws, input logic [15:0] dbs);
    reg_wr(4'd1, 16'(w_m1)); reg_wr(4'd2, 16'(b_m1));
    reg_wr(4'd3, sws); reg_wr(4'd4, dws); reg_wr(4'd5, sbs); reg_wr(4'd6, dbs);
    reg_wr(4'd7, sb);  reg_wr(4'd8, db);
    wn = 0; irq_cnt = 0; irq_with_wr = 1'b0;
  endtask

  // independent walk of the two-level address pattern
  task automatic expect_log(input string req, input int words, input int bursts,
                            input logic [15:0] sb, input logic [15:0] sws, input logic [15:0] sbs,
                            input logic [15:0] db, input logic [15:0] dws, input logic [15:0] dbs);
    logic [15:0] s, d;
    s = sb; d = db;
    check(wn == words * bursts, req, "write count", wn, words * bursts);
    for (int b = 0; b < bursts; b++)
      for (int w = 0; w < words; w++) begin
        int k;
        k = b * words + w;
        check(wa[k] == d, req, $sformatf("write %0d addr", k), int'(wa[k]), int'(d));
        check(wd[k] == mem[s[7:0]], req, $sformatf("write %0d data", k), int'(wd[k]), int'(mem[s[7:0]]));
        if (w == words - 1) begin s = s + sbs; d = d + dbs; end
        else begin s = s + sws; d = d + dws; end
      end
  endtask

  task automatic t_reset();
    logic [15:0] v;
    reg_rd(4'd0, v);
    check(v == 16'h0, "R1", "status after reset", v, 0);
    check(!mem_rd_en && !dst_wr_en && !irq, "R1", "strobes after reset",
          {mem_rd_en, dst_wr_en, irq}, 0);
    reg_rd(4'd9, v);
    check(v == 16'hFFFF, "R10", "wrap size reset", v, 16'hFFFF);
  endtask

  task automatic t_basic();
    logic [15:0] v;
    setup(1, 2, 16'h0010, 16'h0001, 16'h0001, 16'h0040, 16'h0000, 16'h0000);
    reg_wr(4'd0, 16'h0001);
    idle(4);
    check(wn == 0, "R5", "no write without event", wn, 0);
    reg_rd(4'd0, v);
    check(v == 16'h0001, "R9", "running after run", v, 1);
    pulse_evt();
    check(!mem_rd_en, "R12", "no read one cycle after event", mem_rd_en, 0);
    @(negedge clk);
    check(mem_rd_en && mem_rd_addr == 16'h0010, "R5", "first read two cycles after event",
          int'(mem_rd_addr), 16'h0010);
    @(negedge clk);
    check(!mem_rd_en && !dst_wr_en, "R12", "read strobe one cycle", {mem_rd_en, dst_wr_en}, 0);
    @(negedge clk);
    check(mem_rd_en && dst_wr_en, "R12", "write two cycles after read", {mem_rd_en, dst_wr_en}, 3);
    idle(6);
    reg_rd(4'd11, v);
    check(v == 16'd1, "R10", "burst count after first burst", v, 1);
    reg_rd(4'd12, v);
    check(v == 16'hFFFE, "R10", "wrap count after first burst", v, 16'hFFFE);
    pulse_evt(); idle(8);
    pulse_evt(); idle(8);
    expect_log("R2", 2, 3, 16'h0010, 16'h0001, 16'h0001, 16'h0040, 16'h0000, 16'h0000);
    check(irq_cnt == 1, "R9", "one interrupt", irq_cnt, 1);
    check(irq_with_wr, "R9", "irq with last write", irq_with_wr, 1);
    reg_rd(4'd0, v);
    check(v == 16'h0000, "R9", "running cleared", v, 0);
  endtask

  task automatic t_steps();
    logic [15:0] v;
    setup(2, 1, 16'h0080, 16'h0002, 16'hFFFD, 16'h0020, 16'h0001, 16'hFFFE);
    reg_wr(4'd0, 16'h0001);
    reg_wr(4'd0, 16'h0004); idle(8);
    check(wn == 3, "R7", "force starts one burst", wn, 3);
    reg_wr(4'd0, 16'h0004); idle(8);
    expect_log("R3", 3, 2, 16'h0080, 16'h0002, 16'hFFFD, 16'h0020, 16'h0001, 16'hFFFE);
    reg_rd(4'd13, v);
    check(v == 16'h0082, "R4", "source after burst step", v, 16'h0082);
    reg_rd(4'd14, v);
    check(v == 16'h0020, "R4", "dest after burst step", v, 16'h0020);
  endtask

  task automatic t_negwrap();
    logic [15:0] v;
    setup(2, 0, 16'h0001, 16'hFFFF, 16'h0000, 16'h0030, 16'h0000, 16'h0000);
    reg_wr(4'd0, 16'h0005);
    idle(10);
    expect_log("R11", 3, 1, 16'h0001, 16'hFFFF, 16'h0000, 16'h0030, 16'h0000, 16'h0000);
    reg_rd(4'd13, v);
    check(v == 16'hFFFF, "R11", "source wraps below zero", v, 16'hFFFF);
  endtask

  task automatic t_evt_during();
    setup(3, 1, 16'h0050, 16'h0001, 16'h0001, 16'h0060, 16'h0001, 16'h0001);
    reg_wr(4'd0, 16'h0001);
    pulse_evt();
    idle(2);
    pulse_evt();
    idle(20);
    expect_log("R6", 4, 2, 16'h0050, 16'h0001, 16'h0001, 16'h0060, 16'h0001, 16'h0001);
    check(irq_cnt == 1, "R6", "transfer completed", irq_cnt, 1);
  endtask

  task automatic t_halt();
    logic [15:0] v;
    setup(0, 1, 16'h0005, 16'h0000, 16'h0001, 16'h0070, 16'h0000, 16'h0000);
    reg_wr(4'd0, 16'h0001);
    reg_wr(4'd0, 16'h0002);
    pulse_evt(); idle(6);
    check(wn == 0, "R8", "no burst while halted", wn, 0);
    reg_rd(4'd0, v);
    check(v == 16'h0007, "R8", "status halted with flag", v, 7);
    reg_wr(4'd0, 16'h0008); idle(6);
    check(wn == 1, "R8", "burst after resume", wn, 1);
    reg_rd(4'd0, v);
    check(v == 16'h0001, "R5", "flag cleared by burst", v, 1);
    pulse_evt(); idle(6);
    expect_log("R8", 1, 2, 16'h0005, 16'h0000, 16'h0001, 16'h0070, 16'h0000, 16'h0000);
  endtask

  task automatic t_done();
    logic [15:0] v;
    int n0;
    n0 = wn;
    pulse_evt(); idle(8);
    check(wn == n0, "R9", "no burst after completion", wn, n0);
    reg_rd(4'd0, v);
    check(v == 16'h0004, "R9", "flag held while idle", v, 4);
    reg_wr(4'd0, 16'h0001); idle(8);
    check(wn == n0 + 1, "R9", "run restarts transfer", wn, n0 + 1);
    check(wa[n0] == 16'h0070 && wd[n0] == mem[8'h05], "R4", "addresses reloaded by run",
          int'(wa[n0]), 16'h0070);
    reg_rd(4'd11, v);
    check(v == 16'd0, "R10", "burst count reloaded then stepped", v, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_steps();
    t_negwrap();
    t_evt_during();
    t_halt();
    t_done();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule